// File: doc/BRIEF.md
# Clock-Source Control Register Block

This block holds the software-visible settings of a microcontroller clock system in seven byte-wide registers behind a simple register port: one address bus, a write strobe, write data and a combinational read-data bus. It covers the main control word and its status mirror, external-oscillator settings, oscillator-failure supervision, a 32 kHz calibration byte, PLL source and multiplier, and DFLL settings. No oscillator, PLL lock timing or clock switching is modelled; the block only stores, masks, validates and reports.

Several registers are not plain storage. The control word is masked on write and copied into the status register. Both of these registers always show their two ready bits set. The failure-detect enable can be switched on only while a protection-unlock input is high and can never be switched off again. The failure flag is raised by a hardware event and cleared by writing a one to it. A reserved PLL source code is refused. Every refused write is reported on a one-cycle error pulse.

Top module: `clksrc_regs`

## Requirements
- R1: After reset every stored field is zero, so offsets 2 to 6 read 0x00 and offsets 0 and 1 read 0x30.
- R2: A write to offset 0 (control) keeps bits [4:0] and clears the rest. The same masked value is also stored in offset 1 (status).
- R3: A read of offset 0 or offset 1 returns the stored value ORed with 0x30, so bits 5 and 4 always read as one.
- R4: A write to offset 2 (external-oscillator control) stores the byte with bit 4 cleared (value AND 0xEF).
- R5: At offset 3, bit 0 is the failure-detect enable. A write of 1 sets it only if `prot_unlock` is high in the same cycle. Once it is set, no write clears it, and a reset does.
- R6: At offset 3, bit 1 is the failure flag. A `osc_fail_evt` pulse sets it while the enable is set and has no effect while the enable is clear. Writing 1 to bit 1 clears the flag, and writing 0 leaves it unchanged.
- R7: At offset 5 (PLL control), bits [7:6] hold the source code and bits [4:0] the multiplier; bit 5 reads 0. A write with source code 1 leaves the stored source unchanged but still stores the multiplier.
- R8: Offset 6 (DFLL control) keeps only bits [1:0]. Offset 4 (32 kHz calibration) stores the full byte.
- R9: `write_error` is high for exactly the cycle after a write that carries source code 1 to offset 5, a write that tries to set the enable without unlock, or a write of 0 to bit 0 while the enable is set. Otherwise it is low.
- R10: Offset 7 reads 0x00, and a write to it changes no other register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (3) | Register offset for both read and write |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| prot_unlock | input | 1 | Protection unlock, needed to turn on failure detection |
| osc_fail_evt | input | 1 | Oscillator-failure event that sets the failure flag |
| write_error | output | 1 | One-cycle pulse for a refused write |

## Verification
The bench aims at the places where a plausible design would go wrong. A missing status mirror would leave offset 1 at 0x30 after a control write. A forgotten ready OR would show bits 5:4 clear. An unmasked external-oscillator write would return 0xFF instead of 0xEF. For the protected enable, the bench tries to set it without unlock, sets it with unlock, and then tries to clear it. A design that is not sticky or not protected would show a changed bit 0 and no error pulse. The bench also writes the reserved PLL source with a new multiplier. A design that drops the whole write, or that accepts the source, reads back a different byte. The failure flag is tested while gated off, then set, then written with 0 and with 1, which separates a write-one-to-clear flag from a plain stored bit.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
   // Register offsets; software and the read mux both depend on them.
   localparam int unsigned OFF_CTRL   = 0;
   localparam int unsigned OFF_STATUS = 1;
   localparam int unsigned OFF_XOSC   = 2;
   localparam int unsigned OFF_FAIL   = 3;
   localparam int unsigned OFF_CAL    = 4;
   localparam int unsigned OFF_PLL    = 5;
   localparam int unsigned OFF_DFLL   = 6;

   localparam logic [7:0] READY_BITS = 8'h30;
   localparam logic [7:0] XOSC_KEEP  = 8'hEF;

   typedef enum logic [1:0] {
      PLL_SRC_INT2M  = 2'd0,
      PLL_SRC_RSVD   = 2'd1,
      PLL_SRC_INT32M = 2'd2,
      PLL_SRC_EXT    = 2'd3
   } pll_src_e;
endpackage

// File: rtl/clksrc_fail_ctl.sv
module clksrc_fail_ctl #(
   parameter bit GATE_FLAG_BY_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [1:0] wd,
   input  logic       unlock,
   input  logic       fail_evt,
   output logic       en_o,
   output logic       flag_o,
   output logic       err_o
);
   logic set_req, clr_req, flag_set;

   assign set_req = wr &  wd[0] & ~en_o;
   assign clr_req = wr & ~wd[0] &  en_o;
   assign err_o   = (set_req & ~unlock) | clr_req;

   generate
      if (GATE_FLAG_BY_EN) begin : g_gated
         assign flag_set = fail_evt & en_o;
      end else begin : g_free
         assign flag_set = fail_evt;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o   <= 1'b0;
         flag_o <= 1'b0;
      end else begin
         if (set_req && unlock) en_o <= 1'b1;
         if (flag_set)          flag_o <= 1'b1;
         else if (wr && wd[1])  flag_o <= 1'b0;
      end
   end

   // R5: enable is sticky
   p_en_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      en_o |=> en_o);
   // R5: enable rises only through an unlocked write
   p_en_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_o && !(wr && unlock)) |=> !en_o);
   // R6: write-one clears the flag when no event competes
   p_flag_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wd[1] && !fail_evt) |=> !flag_o);
endmodule

// File: rtl/clksrc_pll_ctl.sv
module clksrc_pll_ctl #(
   parameter int unsigned FAC_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [1:0]           wd_src,
   input  logic [FAC_W-1:0]     wd_fac,
   output clksrc_pkg::pll_src_e src_o,
   output logic [FAC_W-1:0]     fac_o,
   output logic                 err_o
);
   import clksrc_pkg::*;

   logic bad_src;
   assign bad_src = (wd_src == PLL_SRC_RSVD);
   assign err_o   = wr & bad_src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_o <= PLL_SRC_INT2M;
         fac_o <= '0;
      end else if (wr) begin
         fac_o <= wd_fac;
         if (!bad_src) src_o <= pll_src_e'(wd_src);
      end
   end

   // R7: reserved source leaves the stored source alone
   p_src_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bad_src) |=> $stable(src_o));
   // R7: multiplier is stored on every write
   p_fac_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (fac_o == $past(wd_fac)));
endmodule

// File: rtl/clksrc_regs.sv
module clksrc_regs #(
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned CTRL_W      = 5,
   parameter int unsigned PLL_FAC_W   = 5,
   parameter int unsigned DFLL_W      = 2,
   parameter bit          FLAG_GATED  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              prot_unlock,
   input  logic              osc_fail_evt,
   output logic              write_error
);
   import clksrc_pkg::*;

   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
   localparam logic [ADDR_W-1:0] A_XOSC   = ADDR_W'(OFF_XOSC);
   localparam logic [ADDR_W-1:0] A_FAIL   = ADDR_W'(OFF_FAIL);
   localparam logic [ADDR_W-1:0] A_CAL    = ADDR_W'(OFF_CAL);
   localparam logic [ADDR_W-1:0] A_PLL    = ADDR_W'(OFF_PLL);
   localparam logic [ADDR_W-1:0] A_DFLL   = ADDR_W'(OFF_DFLL);

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must cover seven offsets");
      end
      if (CTRL_W > 8 || PLL_FAC_W > 5 || DFLL_W > 8) begin : g_bad_width
         $error("field width exceeds its byte slot");
      end
   endgenerate

   logic [CTRL_W-1:0]    ctrl_q, status_q;
   logic [7:0]           xosc_q, cal_q;
   logic [DFLL_W-1:0]    dfll_q;
   logic                 fail_en, fail_flag, fail_err;
   pll_src_e             pll_src;
   logic [PLL_FAC_W-1:0] pll_fac;
   logic                 pll_err;
   logic                 wr_fail, wr_pll;

   assign wr_fail = reg_wr && (reg_addr == A_FAIL);
   assign wr_pll  = reg_wr && (reg_addr == A_PLL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         status_q <= '0;
         xosc_q   <= '0;
         cal_q    <= '0;
         dfll_q   <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            A_CTRL: begin
               ctrl_q   <= reg_wdata[CTRL_W-1:0];
               status_q <= reg_wdata[CTRL_W-1:0];
            end
            A_XOSC:  xosc_q <= reg_wdata & XOSC_KEEP;
            A_CAL:   cal_q  <= reg_wdata;
            A_DFLL:  dfll_q <= reg_wdata[DFLL_W-1:0];
            default: ;
         endcase
      end
   end

   clksrc_fail_ctl #(.GATE_FLAG_BY_EN(FLAG_GATED)) i_fail (
      .clk(clk), .rst_n(rst_n), .wr(wr_fail), .wd(reg_wdata[1:0]),
      .unlock(prot_unlock), .fail_evt(osc_fail_evt),
      .en_o(fail_en), .flag_o(fail_flag), .err_o(fail_err)
   );

   clksrc_pll_ctl #(.FAC_W(PLL_FAC_W)) i_pll (
      .clk(clk), .rst_n(rst_n), .wr(wr_pll), .wd_src(reg_wdata[7:6]),
      .wd_fac(reg_wdata[PLL_FAC_W-1:0]),
      .src_o(pll_src), .fac_o(pll_fac), .err_o(pll_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) write_error <= 1'b0;
      else        write_error <= fail_err | pll_err;
   end

   always_comb begin
      reg_rdata = 8'h00;
      case (reg_addr)
         A_CTRL:   reg_rdata = 8'(ctrl_q)   | READY_BITS;
         A_STATUS: reg_rdata = 8'(status_q) | READY_BITS;
         A_XOSC:   reg_rdata = xosc_q;
         A_FAIL:   reg_rdata = {6'b0, fail_flag, fail_en};
         A_CAL:    reg_rdata = cal_q;
         A_PLL: begin
            reg_rdata[7:6]           = pll_src;
            reg_rdata[PLL_FAC_W-1:0] = pll_fac;
         end
         A_DFLL:   reg_rdata = 8'(dfll_q);
         default:  reg_rdata = 8'h00;
      endcase
   end

   // R2: control write is mirrored into status
   p_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_CTRL) |=> (status_q == ctrl_q));
   // R3: ready bits always visible
   p_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_CTRL || reg_addr == A_STATUS) |-> (reg_rdata[5:4] == 2'b11));
   // R9: a reserved source write is reported next cycle
   p_err_pll_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pll && reg_wdata[7:6] == 2'd1) |=> write_error);
   // R9: no refused write, no pulse
   p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> !write_error);
endmodule

// File: tb/test_clksrc_regs.sv
module test_clksrc_regs;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       prot_unlock = 1'b0;
   logic       osc_fail_evt = 1'b0;
   logic       write_error;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   clksrc_regs i_clksrc_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prot_unlock(prot_unlock),
      .osc_fail_evt(osc_fail_evt), .write_error(write_error)
   );

   // {wen, waddr, wdata, unlock, raddr, exp_rdata, exp_err, req}
   localparam int NV = 13;
   localparam logic [28:0] VEC [NV] = '{
      {1'b1,3'd0,8'hFF,1'b0,3'd1,8'h3F,1'b0,4'd2},  // R2 mirror into status
      {1'b1,3'd0,8'h02,1'b0,3'd0,8'h32,1'b0,4'd3},  // R3 ready bits
      {1'b1,3'd2,8'hFF,1'b0,3'd2,8'hEF,1'b0,4'd4},  // R4 bit 4 dropped
      {1'b1,3'd3,8'h01,1'b0,3'd3,8'h00,1'b1,4'd5},  // R5 locked set refused
      {1'b1,3'd3,8'h01,1'b1,3'd3,8'h01,1'b0,4'd5},  // R5 unlocked set
      {1'b1,3'd3,8'h00,1'b1,3'd3,8'h01,1'b1,4'd5},  // R5 clear refused
      {1'b1,3'd5,8'h9F,1'b0,3'd5,8'h9F,1'b0,4'd7},  // R7 src 2, fac 31
      {1'b1,3'd5,8'h43,1'b0,3'd5,8'h83,1'b1,4'd7},  // R7 reserved src
      {1'b1,3'd5,8'hFF,1'b0,3'd5,8'hDF,1'b0,4'd7},  // R7 bit 5 reads 0
      {1'b1,3'd6,8'hFF,1'b0,3'd6,8'h03,1'b0,4'd8},  // R8 dfll mask
      {1'b1,3'd4,8'hA5,1'b0,3'd4,8'hA5,1'b0,4'd8},  // R8 full byte
      {1'b1,3'd7,8'hFF,1'b0,3'd7,8'h00,1'b0,4'd10}, // R10 hole reads 0
      {1'b0,3'd0,8'h00,1'b0,3'd4,8'hA5,1'b0,4'd10}  // R10 others untouched
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [2:0] a, input logic [7:0] d, input logic u);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1; prot_unlock = u;
      @(negedge clk);
      reg_wr = 1'b0; prot_unlock = 1'b0;
   endtask

   task automatic idle_read(input logic [2:0] a);
      @(negedge clk);
      reg_addr = a;
      #1;
   endtask

   task automatic fail_pulse();
      @(negedge clk);
      osc_fail_evt = 1'b1;
      @(negedge clk);
      osc_fail_evt = 1'b0;
   endtask

   task automatic check_reset(input string tag);
      for (int a = 0; a < 8; a++) begin
         reg_addr = 3'(a);
         #1;
         check(tag, reg_rdata, (a < 2) ? 8'h30 : 8'h00);
      end
      check({tag, " err"}, {7'b0, write_error}, 8'h00);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_reset("R1");

      for (int i = 0; i < NV; i++) begin
         logic [28:0] v;
         string tag;
         v = VEC[i];
         tag = $sformatf("R%0d vec%0d", v[3:0], i);
         if (v[28]) begin
            do_write(v[27:25], v[24:17], v[16]);
            reg_addr = v[15:13];
            #1;
         end else begin
            idle_read(v[15:13]);
         end
         check(tag, reg_rdata, v[12:5]);
         check({tag, " err"}, {7'b0, write_error}, {7'b0, v[4]});
      end

      // R9: pulse lasts one cycle
      do_write(3'd5, 8'h40, 1'b0);
      #1;
      check("R9 pulse", {7'b0, write_error}, 8'h01);
      idle_read(3'd5);
      check("R9 pulse end", {7'b0, write_error}, 8'h00);

      // R1: reset mid-run restores all defaults
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_reset("R1 rerun");

      // R6: event ignored while enable clear
      fail_pulse();
      idle_read(3'd3);
      check("R6 gated", reg_rdata, 8'h00);
      do_write(3'd3, 8'h01, 1'b1);
      fail_pulse();
      idle_read(3'd3);
      check("R6 set", reg_rdata, 8'h03);
      do_write(3'd3, 8'h01, 1'b0);
      reg_addr = 3'd3;
      #1;
      check("R6 write0 keeps", reg_rdata, 8'h03);
      check("R6 write0 err", {7'b0, write_error}, 8'h00);
      do_write(3'd3, 8'h03, 1'b0);
      reg_addr = 3'd3;
      #1;
      check("R6 w1c", reg_rdata, 8'h01);
      check("R5 sticky err", {7'b0, write_error}, 8'h00);

      // R10: write to hole leaves control and status alone
      do_write(3'd0, 8'h15, 1'b0);
      do_write(3'd7, 8'hAA, 1'b0);
      reg_addr = 3'd1;
      #1;
      check("R10 status kept", reg_rdata, 8'h35);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule